// File: doc/BRIEF.md
# Transition-Counting Loss-of-Signal Detector

This block watches a serial NRZ bit stream that is sampled once per unit interval (UI) by a bit clock. It raises a loss-of-signal flag when the line goes quiet. The flag sets when no data transition has been seen for a set number of bit clocks. That number stands for a fixed silence time: the default, 358 UI, is about 2.3 µs at 155.52 Mb/s. The flag clears only when the stream shows enough transition density. The block checks this over back-to-back, non-overlapping 32-UI windows and needs more than four transitions in one window.

While the flag is set, the data passed downstream is forced to logic 0. The detector can be switched off by a plain enable, by a local loopback mode or by a receive monitor mode. While it is off, the flag stays low, the data passes through unchanged and the internal counters are held cleared. After reset the flag is high, so the link counts as lost until the clearing test first passes.

Top module: `los_transition_detector`

## Requirements
- R1: During and after reset, before any clock edge with reset released, `los` is 1 and `data_out` is 0. The stored previous sample resets to 0.
- R2: A transition is a sampled `data_in` that differs from the sample taken on the previous clock edge. The first sample after reset is compared with 0.
- R3: While detection is active and `los` is 0, `los` goes to 1 on the clock edge at which SILENCE_UI consecutive samples without a transition have been taken.
- R4: Any transition restarts the silence count from zero. A transition seen while `los` is 0 and detection is active therefore leaves `los` at 0 on that edge.
- R5: While `los` is 1 and detection is active, samples are grouped into consecutive windows of WIN_UI samples. The first window starts with the first sample after `los` rose, after reset, or after detection resumed. `los` goes to 0 on the edge that takes the last sample of a window holding more than CLEAR_MIN transitions.
- R6: A window holding CLEAR_MIN or fewer transitions leaves `los` at 1, and the next window starts from zero.
- R7: `data_out` holds the sample taken on the latest clock edge when `los` is 0 after that edge, and holds 0 when `los` is 1.
- R8: With `enable` low, `los` is 0 after the edge, `data_out` follows the data, and the silence and window counts are cleared.
- R9: With `loopback_en` high, detection is disabled exactly as in R8.
- R10: With `monitor_en` high, detection is disabled exactly as in R8.
- R11: When detection resumes, `los` stays 0, and the silence count starts from zero at the first enabled sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one edge per UI |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Detection enable |
| loopback_en | input | 1 | Local loopback active; disables detection |
| monitor_en | input | 1 | Receive monitor mode active; disables detection |
| data_in | input | 1 | Sampled NRZ data |
| los | output | 1 | Loss-of-signal flag |
| data_out | output | 1 | Registered data, forced to 0 while `los` is 1 |

## Verification
The bench builds the block with its default parameters: a 358-UI silence limit, a 32-UI window and a clearing threshold of four transitions. At these values the exact assert edge and the exact window-end clear edge are reached within a few hundred cycles. That leaves room for several timeouts, a window holding exactly the threshold count, and a disable/resume pass through each of the three controls. A behavioural model is compared with the flag and the data output on every clock. Directed checks then pin the one-cycle boundaries on either side of each threshold.

// File: rtl/los_pkg.sv
package los_pkg;

    typedef enum logic {
        LINK_OK   = 1'b0,
        LINK_LOST = 1'b1
    } link_state_e;

    typedef struct packed {
        link_state_e state;
        logic        dout;
    } top_regs_t;

endpackage

// File: rtl/los_bit_history.sv
module los_bit_history (
    input  logic clk,
    input  logic rst_n,
    input  logic data_in,
    output logic trans,
    output logic last_bit
);
    typedef struct packed {
        logic prev;
    } hist_t;

    hist_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.prev = data_in;
        trans    = data_in ^ r_q.prev;
        last_bit = r_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/los_silence_timer.sv
module los_silence_timer #(
    parameter int LIMIT = 358
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic trans,
    output logic expire
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] CAP  = CW'(LIMIT);
    localparam logic [CW-1:0] NEAR = CW'(LIMIT - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } sil_t;

    sil_t r_d, r_q;

    always_comb begin
        r_d    = r_q;
        expire = 1'b0;
        if (clr || trans) begin
            r_d.cnt = '0;
        end else begin
            if (r_q.cnt < CAP) r_d.cnt = r_q.cnt + 1'b1;
            expire = (r_q.cnt >= NEAR);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/los_density_window.sv
module los_density_window #(
    parameter int WIN   = 32,
    parameter int MIN_T = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic trans,
    output logic pass
);
    localparam int PW = (WIN > 1) ? $clog2(WIN) : 1;
    localparam int CW = $clog2(WIN + 1);
    localparam logic [PW-1:0] LAST  = PW'(WIN - 1);
    localparam logic [CW-1:0] MIN_C = CW'(MIN_T);

    typedef struct packed {
        logic [PW-1:0] pos;
        logic [CW-1:0] cnt;
    } win_t;

    win_t          r_d, r_q;
    logic [CW-1:0] total;

    always_comb begin
        r_d   = r_q;
        pass  = 1'b0;
        total = r_q.cnt + CW'(trans);
        if (!active) begin
            r_d = '0;
        end else if (r_q.pos == LAST) begin
            pass = (total > MIN_C);
            r_d  = '0;
        end else begin
            r_d.pos = r_q.pos + 1'b1;
            r_d.cnt = total;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/los_transition_detector.sv
module los_transition_detector
    import los_pkg::*;
#(
    parameter int SILENCE_UI = 358,
    parameter int WIN_UI     = 32,
    parameter int CLEAR_MIN  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic loopback_en,
    input  logic monitor_en,
    input  logic data_in,
    output logic los,
    output logic data_out
);
    top_regs_t r_d, r_q;
    logic      det_en;
    logic      trans;
    logic      last_bit;
    logic      expire;
    logic      pass;

    assign det_en = enable && !loopback_en && !monitor_en;

    los_bit_history u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .data_in  (data_in),
        .trans    (trans),
        .last_bit (last_bit)
    );

    los_silence_timer #(.LIMIT(SILENCE_UI)) u_sil (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (!det_en),
        .trans  (trans),
        .expire (expire)
    );

    los_density_window #(.WIN(WIN_UI), .MIN_T(CLEAR_MIN)) u_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (det_en && (r_q.state == LINK_LOST)),
        .trans  (trans),
        .pass   (pass)
    );

    always_comb begin
        r_d = r_q;
        if (!det_en) begin
            r_d.state = LINK_OK;
        end else if (r_q.state == LINK_LOST) begin
            if (pass) r_d.state = LINK_OK;
        end else if (expire) begin
            r_d.state = LINK_LOST;
        end
        r_d.dout = (r_d.state == LINK_LOST) ? 1'b0 : data_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= LINK_LOST;
            r_q.dout  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign los      = (r_q.state == LINK_LOST);
    assign data_out = r_q.dout;

    logic unused_last;
    assign unused_last = last_bit;
endmodule

// File: rtl/los_transition_detector_chk.sv
module los_transition_detector_chk #(
    parameter int WIN_UI = 32
) (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic loopback_en,
    input logic monitor_en,
    input logic data_in,
    input logic los,
    input logic data_out
);
    logic det;
    int   pos;

    assign det = enable && !loopback_en && !monitor_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          pos <= 0;
        else if (los && det) pos <= (pos == WIN_UI - 1) ? 0 : pos + 1;
        else                 pos <= 0;
    end

    assert_squelch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        los |-> !data_out);

    assert_enable_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !los);

    assert_loopback_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        loopback_en |=> !los);

    assert_monitor_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        monitor_en |=> !los);

    assert_transition_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!los && det && (data_in != data_out)) |=> !los);

    assert_rise_only_enabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(los) |-> $past(det));

    assert_clear_at_window_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(los) && $past(det)) |-> ($past(pos) == WIN_UI - 1));
endmodule

bind los_transition_detector los_transition_detector_chk #(.WIN_UI(WIN_UI)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .loopback_en (loopback_en),
    .monitor_en  (monitor_en),
    .data_in     (data_in),
    .los         (los),
    .data_out    (data_out)
);

// File: tb/los_transition_detector_test.sv
module los_transition_detector_test;
    localparam int CLK_PERIOD = 10;
    localparam int SIL = 358;
    localparam int WIN = 32;
    localparam int MIN = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b1;
    logic loopback_en = 1'b0;
    logic monitor_en = 1'b0;
    logic data_in = 1'b0;
    logic los;
    logic data_out;

    int checks = 0;
    int failures = 0;
    logic level = 1'b0;

    // behavioural reference state
    int m_los = 1, m_prev = 0, m_sil = 0, m_wpos = 0, m_wcnt = 0, m_dout = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    los_transition_detector uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .loopback_en(loopback_en),
        .monitor_en(monitor_en), .data_in(data_in), .los(los), .data_out(data_out)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_los = 1; m_prev = 0; m_sil = 0; m_wpos = 0; m_wcnt = 0; m_dout = 0;
        end else begin
            int d;
            int tr;
            d  = int'(data_in);
            tr = (d != m_prev) ? 1 : 0;
            m_prev = d;
            if (!enable || loopback_en || monitor_en) begin
                m_los = 0; m_sil = 0; m_wpos = 0; m_wcnt = 0;
            end else begin
                m_sil = tr ? 0 : m_sil + 1;
                if (m_los == 0) begin
                    if (m_sil >= SIL) begin
                        m_los = 1; m_wpos = 0; m_wcnt = 0;
                    end
                end else begin
                    m_wcnt = m_wcnt + tr;
                    m_wpos = m_wpos + 1;
                    if (m_wpos == WIN) begin
                        if (m_wcnt > MIN) m_los = 0;
                        m_wpos = 0; m_wcnt = 0;
                    end
                end
            end
            m_dout = m_los ? 0 : d;
        end
    end

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            check(los, m_los[0], "R3/R5 model los");
            check(data_out, m_dout[0], "R7 model data_out");
        end
    end

    task automatic step(input logic b);
        data_in = b;
        level = b;
        @(negedge clk);
    endtask

    task automatic hold(input int n);
        for (int i = 0; i < n; i++) step(level);
    endtask

    task automatic toggles(input int n);
        for (int i = 0; i < n; i++) step(~level);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(los, 1'b1, "R1 reset los");
        check(data_out, 1'b0, "R1 reset data_out");
        rst_n = 1'b1;

        // R2/R5: first sample 1 differs from reset 0; 32 toggles clear at window end
        toggles(WIN - 1);
        check(los, 1'b1, "R5 los before window end");
        toggles(1);
        check(los, 1'b0, "R5 R2 los cleared at window end");

        // R3: timeout edge
        hold(SIL - 1);
        check(los, 1'b0, "R3 one sample before timeout");
        hold(1);
        check(los, 1'b1, "R3 los at timeout");

        // R6: window with exactly MIN transitions does not clear
        toggles(MIN); hold(WIN - MIN);
        check(los, 1'b1, "R6 threshold window keeps los");
        toggles(MIN + 1); hold(WIN - MIN - 2);
        check(los, 1'b1, "R5 second window not yet ended");
        hold(1);
        check(los, 1'b0, "R5 second window clears");

        // R4: a transition restarts silence count
        hold(200);
        toggles(1);
        hold(SIL - 1);
        check(los, 1'b0, "R4 restart after transition");
        hold(1);
        check(los, 1'b1, "R4 timeout after restart");

        // R7: squelch and passthrough
        toggles(1);
        check(data_out, 1'b0, "R7 squelched while los");
        toggles(WIN - 1);
        check(los, 1'b0, "R5 clear before pass test");
        step(1'b1);
        check(data_out, 1'b1, "R7 pass 1");
        step(1'b0);
        check(data_out, 1'b0, "R7 pass 0");
        step(1'b1);

        // R8: disabled via enable, long silence
        enable = 1'b0;
        hold(500);
        check(los, 1'b0, "R8 los low while disabled");
        check(data_out, 1'b1, "R8 data passes while disabled");

        // R11: resume starts silence from zero
        enable = 1'b1;
        hold(SIL - 1);
        check(los, 1'b0, "R11 no early assert after resume");
        hold(1);
        check(los, 1'b1, "R11 assert after full limit");

        // R9: loopback forces los off
        loopback_en = 1'b1;
        hold(1);
        check(los, 1'b0, "R9 loopback clears los");
        check(data_out, 1'b1, "R9 data passes in loopback");
        hold(500);
        check(los, 1'b0, "R9 loopback long silence");
        loopback_en = 1'b0;
        hold(SIL);
        check(los, 1'b1, "R11 timeout after loopback");

        // R10: monitor forces los off
        monitor_en = 1'b1;
        step(1'b0);
        check(los, 1'b0, "R10 monitor clears los");
        check(data_out, 1'b0, "R10 data passes in monitor");
        hold(400);
        check(los, 1'b0, "R10 monitor long silence");
        monitor_en = 1'b0;
        hold(SIL);
        check(los, 1'b1, "R10 timeout after monitor");

        // R8: enable low forces los off
        enable = 1'b0;
        step(1'b1);
        check(los, 1'b0, "R8 enable low clears los");
        check(data_out, 1'b1, "R8 data passes after clear");
        enable = 1'b1;
        hold(5);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule